// File: doc/BRIEF.md
# Multi-Store Halfword Block Transfer Engine

The engine copies a counted run of 16-bit halfwords from one store into another. Four stores can be selected on either side: a 64-entry register file, a local store whose depth is a parameter, a byte-addressed main store, and a 128-entry display register file. Each store has its own addressing rule. The register file, the local store and the display file wrap back to entry zero past their last entry. Main store addresses must be even.

A request gives a 3-bit store code and an address for each side, plus a length in halfwords. Each address and the length is presented as a 4-bit base field, a base register value and a 12-bit displacement. A base field of zero means only the displacement counts. A one-cycle start pulse launches the request. The engine then moves one halfword per clock through a combinational read port and a write port. It ends with a one-cycle done pulse, or with a one-cycle fault pulse if the main store alignment rule is broken. The store arrays sit outside the block.

Top module: `halfword_mover`

## Requirements
- R1: Store code 0 selects the register file, 1 the local store, 2 the main store and 3 the display register file. The source code appears on rd_store_o and the destination code on wr_store_o during every step.
- R2: Register file addresses are taken modulo 64 at launch and step by one, going from 63 to 0.
- R3: Local store addresses are taken modulo LS_DEPTH at launch and step by one, going from LS_DEPTH-1 to 0.
- R4: Display register file addresses are taken modulo 128 at launch and step by one, going from 127 to 0.
- R5: Main store addresses are byte addresses and step by 2 per halfword. If a nonzero-length request has an odd (bit 0 = 1) main store address on either side, fault_o pulses for one cycle in the cycle after start, and no read or write is made.
- R6: Store codes 4 to 7 are unused. As a source, an unused code supplies zero data and rd_en_o stays low. As a destination, an unused code keeps wr_en_o low.
- R7: Each address and the length equals the zero-extended displacement when the base field is 0. Otherwise it equals the base value plus the zero-extended displacement, modulo 2^16.
- R8: A zero-length request pulses done_o in the cycle after start. It makes no read or write and does not raise busy_o, even when an address is misaligned.
- R9: A transfer of N halfwords holds busy_o for exactly N cycles with one read and write per cycle. done_o pulses for one cycle in the cycle after the last write. A start pulse while busy_o is high is ignored.
- R10: While rst_ni is low, busy_o, done_o, fault_o, rd_en_o and wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled while idle |
| src_code_i | input | 3 | Source store code |
| src_bfield_i | input | 4 | Source base field; 0 means no base |
| src_bval_i | input | 16 | Source base register value |
| src_disp_i | input | 12 | Source displacement |
| dst_code_i | input | 3 | Destination store code |
| dst_bfield_i | input | 4 | Destination base field |
| dst_bval_i | input | 16 | Destination base register value |
| dst_disp_i | input | 12 | Destination displacement |
| len_bfield_i | input | 4 | Length base field |
| len_bval_i | input | 16 | Length base register value |
| len_disp_i | input | 12 | Length displacement |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle alignment fault pulse |
| rd_en_o | output | 1 | Read strobe for the source store |
| rd_store_o | output | 3 | Source store code of current step |
| rd_addr_o | output | 16 | Source address of current step |
| rd_data_i | input | 16 | Read data, combinational from source store |
| wr_en_o | output | 1 | Write strobe for the destination store |
| wr_store_o | output | 3 | Destination store code of current step |
| wr_addr_o | output | 16 | Destination address of current step |
| wr_data_o | output | 16 | Write data |

## Verification
The assertions assume that request fields only matter in a cycle where start_i is high and the engine is idle. They also assume that rd_data_i settles within the cycle, because the write data passes straight through from it. The assertions never constrain the data values and only check address ranges, alignment and the pulse structure. The bench changes its inputs on falling edges and keeps start_i high for exactly one cycle. Its read model returns a nonzero marker for unused store codes, so a missing zero substitution shows up in the destination contents.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int CW    = 3;
  localparam int BFW   = 4;
  localparam int DISPW = 12;

  localparam logic [CW-1:0] ST_REG   = 3'd0;
  localparam logic [CW-1:0] ST_LOCAL = 3'd1;
  localparam logic [CW-1:0] ST_MAIN  = 3'd2;
  localparam logic [CW-1:0] ST_DISP  = 3'd3;

  localparam int REG_ENTRIES  = 64;
  localparam int DISP_ENTRIES = 128;
  localparam int REG_IW       = $clog2(REG_ENTRIES);
  localparam int DISP_IW      = $clog2(DISP_ENTRIES);
endpackage

// File: rtl/hm_addr_former.sv
module hm_addr_former
  import hm_pkg::*;
(
  input  logic [BFW-1:0]   bfield_i,
  input  logic [AW-1:0]    bval_i,
  input  logic [DISPW-1:0] disp_i,
  output logic [AW-1:0]    sum_o
);
  logic [AW-1:0] disp_ext;
  assign disp_ext = {{(AW-DISPW){1'b0}}, disp_i};
  // field 0 names no base register
  assign sum_o = (bfield_i == '0) ? disp_ext : bval_i + disp_ext;
endmodule

// File: rtl/hm_addr_norm.sv
module hm_addr_norm
  import hm_pkg::*;
#(
  parameter int LS_DEPTH = 96
) (
  input  logic [CW-1:0] code_i,
  input  logic [AW-1:0] raw_i,
  output logic [AW-1:0] addr_o,
  output logic          used_o,
  output logic          misalign_o
);
  localparam logic [AW-1:0] LS_N = AW'(LS_DEPTH);

  always_comb begin
    addr_o = '0;
    used_o = 1'b1;
    unique case (code_i)
      ST_REG:   addr_o = {{(AW-REG_IW){1'b0}}, raw_i[REG_IW-1:0]};
      ST_LOCAL: addr_o = raw_i % LS_N;
      ST_MAIN:  addr_o = raw_i;
      ST_DISP:  addr_o = {{(AW-DISP_IW){1'b0}}, raw_i[DISP_IW-1:0]};
      default:  used_o = 1'b0;
    endcase
  end

  assign misalign_o = (code_i == ST_MAIN) && raw_i[0];
endmodule

// File: rtl/hm_addr_step.sv
module hm_addr_step
  import hm_pkg::*;
#(
  parameter int LS_DEPTH = 96
) (
  input  logic [CW-1:0] code_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] LS_LAST = AW'(LS_DEPTH - 1);

  logic [REG_IW-1:0]  reg_nx;
  logic [DISP_IW-1:0] disp_nx;
  assign reg_nx  = addr_i[REG_IW-1:0] + 1'b1;
  assign disp_nx = addr_i[DISP_IW-1:0] + 1'b1;

  always_comb begin
    unique case (code_i)
      ST_REG:   next_o = {{(AW-REG_IW){1'b0}}, reg_nx};
      ST_LOCAL: next_o = (addr_i == LS_LAST) ? '0 : addr_i + 1'b1;
      ST_MAIN:  next_o = addr_i + AW'(2);  // byte addressed
      ST_DISP:  next_o = {{(AW-DISP_IW){1'b0}}, disp_nx};
      default:  next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/hm_ctrl.sv
module hm_ctrl
  import hm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] len_i,
  input  logic          misalign_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o
);
  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t           st_q;
  logic [AW-1:0] remain_q;
  logic          done_q, fault_q;
  logic          launch;

  assign launch = (st_q == S_IDLE) && start_i;
  assign load_o = launch && (len_i != '0) && !misalign_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      remain_q <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (launch) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else if (misalign_i) begin
              fault_q <= 1'b1;
            end else begin
              st_q     <= S_RUN;
              remain_q <= len_i;
            end
          end
        end
        S_RUN: begin
          remain_q <= remain_q - 1'b1;
          if (remain_q == AW'(1)) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == S_RUN);
  assign done_o  = done_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/halfword_mover.sv
module halfword_mover
  import hm_pkg::*;
#(
  parameter int LS_DEPTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CW-1:0]    src_code_i,
  input  logic [BFW-1:0]   src_bfield_i,
  input  logic [AW-1:0]    src_bval_i,
  input  logic [DISPW-1:0] src_disp_i,
  input  logic [CW-1:0]    dst_code_i,
  input  logic [BFW-1:0]   dst_bfield_i,
  input  logic [AW-1:0]    dst_bval_i,
  input  logic [DISPW-1:0] dst_disp_i,
  input  logic [BFW-1:0]   len_bfield_i,
  input  logic [AW-1:0]    len_bval_i,
  input  logic [DISPW-1:0] len_disp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             rd_en_o,
  output logic [CW-1:0]    rd_store_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [DW-1:0]    rd_data_i,
  output logic             wr_en_o,
  output logic [CW-1:0]    wr_store_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  localparam int SIDES = 2;  // 0 = source, 1 = destination

  logic [SIDES-1:0][CW-1:0]    code_in;
  logic [SIDES-1:0][BFW-1:0]   bf_in;
  logic [SIDES-1:0][AW-1:0]    bv_in;
  logic [SIDES-1:0][DISPW-1:0] dp_in;
  logic [SIDES-1:0][CW-1:0]    cur_code;
  logic [SIDES-1:0][AW-1:0]    cur_addr;
  logic [SIDES-1:0]            cur_used;
  logic [SIDES-1:0]            mis_w;
  logic [AW-1:0]               len_w;
  logic                        load, busy;

  assign code_in = {dst_code_i,   src_code_i};
  assign bf_in   = {dst_bfield_i, src_bfield_i};
  assign bv_in   = {dst_bval_i,   src_bval_i};
  assign dp_in   = {dst_disp_i,   src_disp_i};

  hm_addr_former u_len (
    .bfield_i (len_bfield_i),
    .bval_i   (len_bval_i),
    .disp_i   (len_disp_i),
    .sum_o    (len_w)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [AW-1:0] raw_w, norm_w, next_w, addr_q;
    logic [CW-1:0] code_q;
    logic          used_w, used_q;

    hm_addr_former u_form (
      .bfield_i (bf_in[s]),
      .bval_i   (bv_in[s]),
      .disp_i   (dp_in[s]),
      .sum_o    (raw_w)
    );

    hm_addr_norm #(.LS_DEPTH(LS_DEPTH)) u_norm (
      .code_i     (code_in[s]),
      .raw_i      (raw_w),
      .addr_o     (norm_w),
      .used_o     (used_w),
      .misalign_o (mis_w[s])
    );

    hm_addr_step #(.LS_DEPTH(LS_DEPTH)) u_step (
      .code_i (code_q),
      .addr_i (addr_q),
      .next_o (next_w)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= '0;
        addr_q <= '0;
        used_q <= 1'b0;
      end else if (load) begin
        code_q <= code_in[s];
        addr_q <= norm_w;
        used_q <= used_w;
      end else if (busy) begin
        addr_q <= next_w;
      end
    end

    assign cur_code[s] = code_q;
    assign cur_addr[s] = addr_q;
    assign cur_used[s] = used_q;
  end

  hm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len_w),
    .misalign_i (|mis_w),
    .load_o     (load),
    .busy_o     (busy),
    .done_o     (done_o),
    .fault_o    (fault_o)
  );

  assign busy_o     = busy;
  assign rd_en_o    = busy && cur_used[0];
  assign rd_store_o = cur_code[0];
  assign rd_addr_o  = cur_addr[0];
  assign wr_en_o    = busy && cur_used[1];
  assign wr_store_o = cur_code[1];
  assign wr_addr_o  = cur_addr[1];
  // unused source reads as zero
  assign wr_data_o  = cur_used[0] ? rd_data_i : '0;
endmodule

// File: rtl/hm_checker.sv
module hm_checker
  import hm_pkg::*;
#(
  parameter int LS_DEPTH = 96
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          rd_en_o,
  input logic [CW-1:0] rd_store_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wr_en_o,
  input logic [CW-1:0] wr_store_o,
  input logic [AW-1:0] wr_addr_o
);
  localparam logic [AW-1:0] LS_N = AW'(LS_DEPTH);

  assert_rd_reg_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_store_o == ST_REG) |-> rd_addr_o < AW'(REG_ENTRIES));
  assert_wr_reg_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_store_o == ST_REG) |-> wr_addr_o < AW'(REG_ENTRIES));
  assert_rd_local_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_store_o == ST_LOCAL) |-> rd_addr_o < LS_N);
  assert_wr_local_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_store_o == ST_LOCAL) |-> wr_addr_o < LS_N);
  assert_rd_disp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_store_o == ST_DISP) |-> rd_addr_o < AW'(DISP_ENTRIES));
  assert_wr_disp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_store_o == ST_DISP) |-> wr_addr_o < AW'(DISP_ENTRIES));
  assert_rd_main_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_store_o == ST_MAIN) |-> !rd_addr_o[0]);
  assert_wr_main_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_store_o == ST_MAIN) |-> !wr_addr_o[0]);
  assert_fault_no_access_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!busy_o && !wr_en_o && !rd_en_o));
  assert_wr_used_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_store_o <= ST_DISP);
  assert_rd_used_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_store_o <= ST_DISP);
  assert_access_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || rd_en_o) |-> busy_o);
  assert_end_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pulse_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
endmodule

bind halfword_mover hm_checker #(.LS_DEPTH(LS_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .rd_en_o    (rd_en_o),
  .rd_store_o (rd_store_o),
  .rd_addr_o  (rd_addr_o),
  .wr_en_o    (wr_en_o),
  .wr_store_o (wr_store_o),
  .wr_addr_o  (wr_addr_o)
);

// File: tb/sim_halfword_mover.sv
`timescale 1ns/1ps
module sim_halfword_mover;
  localparam int LS  = 96;
  localparam int MSN = 512;   // main store halfwords modelled

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  src_code_i = '0, dst_code_i = '0;
  logic [3:0]  src_bfield_i = '0, dst_bfield_i = '0, len_bfield_i = '0;
  logic [15:0] src_bval_i = '0, dst_bval_i = '0, len_bval_i = '0;
  logic [11:0] src_disp_i = '0, dst_disp_i = '0, len_disp_i = '0;
  logic        busy_o, done_o, fault_o, rd_en_o, wr_en_o;
  logic [2:0]  rd_store_o, wr_store_o;
  logic [15:0] rd_addr_o, wr_addr_o, wr_data_o;
  logic [15:0] rd_data_i;

  always #5 clk_i = ~clk_i;

  halfword_mover #(.LS_DEPTH(LS)) u0 (.*);

  // stores seen by the design, and the bench's expected copies
  logic [15:0] rf [64],  m_rf [64];
  logic [15:0] ls [LS],  m_ls [LS];
  logic [15:0] ms [MSN], m_ms [MSN];
  logic [15:0] dr [128], m_dr [128];

  int total = 0, bad = 0;

  always_comb begin
    case (rd_store_o)
      3'd0:    rd_data_i = rf[rd_addr_o % 64];
      3'd1:    rd_data_i = ls[rd_addr_o % LS];
      3'd2:    rd_data_i = ms[(rd_addr_o >> 1) % MSN];
      3'd3:    rd_data_i = dr[rd_addr_o % 128];
      default: rd_data_i = 16'hDEAD;  // engine must not pass this on
    endcase
  end

  always @(posedge clk_i) begin
    if (wr_en_o) begin
      case (wr_store_o)
        3'd0: rf[wr_addr_o % 64] <= wr_data_o;
        3'd1: ls[wr_addr_o % LS] <= wr_data_o;
        3'd2: ms[(wr_addr_o >> 1) % MSN] <= wr_data_o;
        3'd3: dr[wr_addr_o % 128] <= wr_data_o;
        default: ;
      endcase
    end
  end

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  sc; logic [3:0] sbf; logic [15:0] sbv; logic [11:0] sd;
    logic [2:0]  dc; logic [3:0] dbf; logic [15:0] dbv; logic [11:0] dd;
    logic [3:0]  lbf; logic [15:0] lbv; logic [11:0] ld;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd7, 3'd0, 4'd0, 16'h1234, 12'd5,   3'd3, 4'd3, 16'd10,   12'd2,  4'd0, 16'd0,  12'd8}, // R1 R7 base ignored
    '{4'd2, 3'd0, 4'd0, 16'd0,    12'd60,  3'd1, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd8}, // R2 63->0
    '{4'd3, 3'd1, 4'd0, 16'd0,    12'd90,  3'd0, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd10},// R3 95->0
    '{4'd3, 3'd1, 4'd0, 16'd0,    12'd100, 3'd3, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd3}, // R3 start reduced
    '{4'd4, 3'd3, 4'd0, 16'd0,    12'd125, 3'd2, 4'd0, 16'd0,    12'h10, 4'd0, 16'd0,  12'd6}, // R4 127->0
    '{4'd5, 3'd2, 4'd0, 16'd0,    12'h20,  3'd0, 4'd0, 16'd0,    12'd10, 4'd0, 16'd0,  12'd5}, // R5 step 2
    '{4'd5, 3'd2, 4'd0, 16'd0,    12'h21,  3'd0, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd4}, // R5 odd source
    '{4'd5, 3'd0, 4'd0, 16'd0,    12'd0,   3'd2, 4'd2, 16'h0040, 12'd3,  4'd0, 16'd0,  12'd4}, // R5 odd dest
    '{4'd6, 3'd5, 4'd0, 16'd0,    12'd0,   3'd0, 4'd0, 16'd0,    12'd20, 4'd0, 16'd0,  12'd4}, // R6 zero source
    '{4'd6, 3'd0, 4'd0, 16'd0,    12'd30,  3'd7, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd4}, // R6 dropped dest
    '{4'd8, 3'd2, 4'd0, 16'd0,    12'h11,  3'd0, 4'd0, 16'd0,    12'd0,  4'd0, 16'd0,  12'd0}, // R8 zero length
    '{4'd7, 3'd0, 4'd1, 16'hFFFF, 12'd3,   3'd3, 4'd0, 16'd0,    12'd40, 4'd2, 16'd3,  12'd2}, // R7 wraps, base len
    '{4'd9, 3'd0, 4'd0, 16'd0,    12'd0,   3'd0, 4'd0, 16'd0,    12'd1,  4'd0, 16'd0,  12'd5}  // R9 overlap order
  };

  function automatic logic [15:0] form(input logic [3:0] bf, input logic [15:0] bv,
                                       input logic [11:0] d);
    return (bf == 0) ? {4'd0, d} : 16'(bv + {4'd0, d});
  endfunction

  function automatic logic [15:0] nrm(input logic [2:0] c, input logic [15:0] a);
    case (c)
      3'd0: return a % 64;
      3'd1: return a % LS;
      3'd2: return a;
      3'd3: return a % 128;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] nxt(input logic [2:0] c, input logic [15:0] a);
    case (c)
      3'd0: return (a + 1) % 64;
      3'd1: return (a + 1) % LS;
      3'd2: return 16'(a + 2);
      3'd3: return (a + 1) % 128;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] mread(input logic [2:0] c, input logic [15:0] a);
    case (c)
      3'd0: return m_rf[a];
      3'd1: return m_ls[a];
      3'd2: return m_ms[(a >> 1) % MSN];
      3'd3: return m_dr[a];
      default: return 0;
    endcase
  endfunction

  task automatic mwrite(input logic [2:0] c, input logic [15:0] a, input logic [15:0] v);
    case (c)
      3'd0: m_rf[a] = v;
      3'd1: m_ls[a] = v;
      3'd2: m_ms[(a >> 1) % MSN] = v;
      3'd3: m_dr[a] = v;
      default: ;
    endcase
  endtask

  task automatic fill(input logic [15:0] seed);
    for (int i = 0; i < 64; i++)  begin rf[i] = 16'h1000 + 16'(i) ^ seed; m_rf[i] = rf[i]; end
    for (int i = 0; i < LS; i++)  begin ls[i] = 16'h2000 + 16'(i) ^ seed; m_ls[i] = ls[i]; end
    for (int i = 0; i < MSN; i++) begin ms[i] = 16'h4000 + 16'(i) ^ seed; m_ms[i] = ms[i]; end
    for (int i = 0; i < 128; i++) begin dr[i] = 16'h8000 + 16'(i) ^ seed; m_dr[i] = dr[i]; end
  endtask

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int diffs = 0;
    for (int i = 0; i < 64; i++)  if (rf[i] !== m_rf[i]) diffs++;
    for (int i = 0; i < LS; i++)  if (ls[i] !== m_ls[i]) diffs++;
    for (int i = 0; i < MSN; i++) if (ms[i] !== m_ms[i]) diffs++;
    for (int i = 0; i < 128; i++) if (dr[i] !== m_dr[i]) diffs++;
    check(tag, diffs == 0, diffs, 0);
  endtask

  // applies a request to the expected stores; returns expected busy cycles and fault
  task automatic model(input vec_t v, output int nb, output bit flt);
    logic [15:0] sa, da, n;
    sa = form(v.sbf, v.sbv, v.sd);
    da = form(v.dbf, v.dbv, v.dd);
    n  = form(v.lbf, v.lbv, v.ld);
    flt = (n != 0) && ((v.sc == 3'd2 && sa[0]) || (v.dc == 3'd2 && da[0]));
    nb = flt ? 0 : int'(n);
    if (flt) return;
    sa = nrm(v.sc, sa);
    da = nrm(v.dc, da);
    for (int k = 0; k < int'(n); k++) begin
      mwrite(v.dc, da, mread(v.sc, sa));
      sa = nxt(v.sc, sa);
      da = nxt(v.dc, da);
    end
  endtask

  task automatic drive(input vec_t v);
    src_code_i = v.sc; src_bfield_i = v.sbf; src_bval_i = v.sbv; src_disp_i = v.sd;
    dst_code_i = v.dc; dst_bfield_i = v.dbf; dst_bval_i = v.dbv; dst_disp_i = v.dd;
    len_bfield_i = v.lbf; len_bval_i = v.lbv; len_disp_i = v.ld;
  endtask

  task automatic wait_end(output int nb, output bit gd, output bit gf, output bit wide);
    nb = 0; gd = 0; gf = 0; wide = 0;
    for (int t = 0; t < 4000; t++) begin
      if (busy_o) nb++;
      if (done_o) gd = 1;
      if (fault_o) gf = 1;
      if (done_o || fault_o) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    wide = done_o || fault_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nb, enb; bit gd, gf, ef, wide;
    fill(16'h0000);
    repeat (3) @(negedge clk_i);
    // R10: quiet under reset
    check("R10 reset outputs", {busy_o, done_o, fault_o, rd_en_o, wr_en_o} == 5'b0,
          int'({busy_o, done_o, fault_o, rd_en_o, wr_en_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int r = 0; r < NV; r++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[r].req, r);
      fill(16'(r * 16'h0101));
      model(TBL[r], enb, ef);
      drive(TBL[r]);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      wait_end(nb, gd, gf, wide);
      check({tag, " fault flag"}, gf == ef && gd == !ef, int'(gf), int'(ef));
      check({tag, " busy cycles (R9)"}, nb == enb, nb, enb);
      check({tag, " single pulse (R9)"}, !wide, int'(wide), 0);
      cmp_mem({tag, " store contents"});
    end

    // R9: start while busy is ignored
    begin
      vec_t a, b;
      fill(16'h5A5A);
      a = TBL[1];
      b = TBL[8];
      model(a, enb, ef);
      drive(a);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      @(negedge clk_i);
      drive(b);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      nb = 2;
      for (int t = 0; t < 100 && !done_o; t++) begin
        if (busy_o) nb++;
        @(negedge clk_i);
      end
      check("R9 busy with ignored start", nb == enb, nb, enb);
      repeat (10) @(negedge clk_i);
      check("R9 no second transfer", !busy_o, int'(busy_o), 0);
      cmp_mem("R9 ignored start contents");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule